// File: doc/BRIEF.md
# Two-Channel Down-Counting Timer

This peripheral holds two identical timer channels behind a 32-bit register bus. The bus has a byte address, a write strobe, write data and combinational read data. Each channel has a 64-bit interval and a 64-bit counter that counts down one step per prescaled tick. A control word selects enable, load-on-start, a 3-bit prescaler and periodic or single-shot operation. When a channel's counter expires, the channel's pending bit is set. A mask register and a write-one-to-clear pending register merge the channels onto one interrupt line.

Software starts a channel by writing the interval and then writing enable together with reload. That write copies the interval into the counter. When the counter is at zero and a tick arrives, the channel expires. In periodic mode it then refills from the interval. In single-shot mode it stops at zero and drops its own enable bit. Turning a channel off is not immediate: the counter keeps counting for two more ticks before it halts. This mirrors a source clock that needs a short synchronisation period.

A channel programmed with an all-ones interval and left in periodic mode wraps continuously. Inverting its low count word then gives an increasing time base.

Top module: `dntimer`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: The register map is as follows. The mask register is at 0x00, with bit n for channel n. The pending register is at 0x04. Channel n control is at 0x20*n+0x10. Interval low and high are at +0x04 and +0x08 from that control address, and count low and high are at +0x0C and +0x10. Unmapped offsets read zero. The count words are read-only, so writes to them change nothing.
- R3: The control layout is: bit 0 enable, bit 1 reload, bits 6:4 prescaler select, bit 7 single-shot (0 = periodic). Bits 3:2 and 31:8 read zero. A control write with both bit 0 and bit 1 set loads the counter from the interval on that same clock edge. No tick is counted on that edge.
- R4: While running, the counter decreases by one per tick. A tick occurs once every 2^sel clock cycles, where sel is the control select field.
- R5: In periodic mode, a tick that finds the counter at zero sets the channel's pending bit and refills the counter from the interval.
- R6: In single-shot mode, a tick that finds the counter at zero sets the pending bit, clears control bit 0 and leaves the counter at zero.
- R7: After a control write that clears enable takes effect, the counter decrements on exactly two more ticks and then holds.
- R8: Writing 1 to pending bit n clears it. Writing 0 leaves it unchanged.
- R9: `irq` is high exactly when some channel has both its pending bit and its mask bit set.
- R10: Interval values below 2 are used as 2 for both load and refill, so the shortest period is 3 ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Byte address of the register access |
| wr_en | input | 1 | Write strobe for the register addressed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is the two-tick tail after a disable write. The tail is only visible if the counter is read on the exact cycles around the moment the write takes effect. The bench starts a channel at the fastest tick rate and reads the count back to back, issuing the disable write between two of those reads. It then checks that the next three reads step down twice and then repeat. The prescaler's phase cannot be seen from the ports, so the tick rate is checked over a whole number of tick periods after a load. That window holds the same number of ticks wherever the divider happens to stand.

// File: rtl/dntimer_pkg.sv
package dntimer_pkg;

  localparam int SEL_W      = 3;
  localparam int SYNC_TICKS = 2;
  localparam int STOP_W     = 2;

  typedef struct packed {
    logic             oneshot;
    logic [SEL_W-1:0] psel;
    logic [1:0]       rsvd;
    logic             reload;
    logic             enable;
  } chan_ctrl_t;

  localparam int CTRL_W = $bits(chan_ctrl_t);

endpackage

// File: rtl/dntimer_prescale.sv
module dntimer_prescale
  import dntimer_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_i [NUM_CH],
  output logic [NUM_CH-1:0] tick_o
);

  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_d;

  always_comb begin
    div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else begin
      div_q <= div_d;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_tick
    logic [DIV_W:0]   one_hot;
    logic [DIV_W-1:0] mask;

    always_comb begin
      one_hot   = (DIV_W+1)'(1) << sel_i[i];
      mask      = DIV_W'(one_hot - 1'b1);
      tick_o[i] = (div_q & mask) == mask;
    end

    // R4: with a nonzero select, two ticks never fall on adjacent cycles
    a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o[i] && sel_i[i] != '0) |=> (!tick_o[i] || !$stable(sel_i[i])));
  end

endmodule

// File: rtl/dntimer_channel.sv
module dntimer_channel
  import dntimer_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int MIN_RELOAD = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic                wr_ctrl_i,
  input  logic                wr_ivl_lo_i,
  input  logic                wr_ivl_hi_i,
  input  logic [WORD_W-1:0]   wdata_i,
  output chan_ctrl_t          ctrl_o,
  output logic [2*WORD_W-1:0] ivl_o,
  output logic [2*WORD_W-1:0] cnt_o,
  output logic                expire_o
);

  localparam int CNT_W = 2 * WORD_W;

  chan_ctrl_t        ctrl_q, ctrl_d, ctrl_wr;
  logic [CNT_W-1:0]  ivl_q, ivl_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  refill;
  logic [STOP_W-1:0] stop_q, stop_d;
  logic              run;
  logic              load;
  logic              at_zero;
  logic              expire;

  always_comb begin
    ctrl_wr         = '0;
    ctrl_wr.enable  = wdata_i[0];
    ctrl_wr.reload  = wdata_i[1];
    ctrl_wr.psel    = wdata_i[4 +: SEL_W];
    ctrl_wr.oneshot = wdata_i[7];
    ctrl_wr.rsvd    = 2'b00;
  end

  always_comb begin
    refill  = (ivl_q < CNT_W'(MIN_RELOAD)) ? CNT_W'(MIN_RELOAD) : ivl_q;
    run     = ctrl_q.enable || (stop_q != '0);
    load    = wr_ctrl_i && ctrl_wr.enable && ctrl_wr.reload;
    at_zero = (cnt_q == '0);
    expire  = tick_i && run && at_zero && !load;
  end

  // interval words
  always_comb begin
    ivl_d = ivl_q;
    if (wr_ivl_lo_i) begin
      ivl_d[WORD_W-1:0] = wdata_i;
    end
    if (wr_ivl_hi_i) begin
      ivl_d[CNT_W-1:WORD_W] = wdata_i;
    end
  end

  // control word and disable tail
  always_comb begin
    ctrl_d = ctrl_q;
    stop_d = stop_q;
    if (tick_i && !ctrl_q.enable && stop_q != '0) begin
      stop_d = stop_q - 1'b1;
    end
    if (expire && ctrl_q.oneshot) begin
      ctrl_d.enable = 1'b0;
      stop_d        = '0;
    end
    if (wr_ctrl_i) begin
      ctrl_d = ctrl_wr;
      if (ctrl_wr.enable) begin
        stop_d = '0;
      end else if (ctrl_q.enable) begin
        stop_d = STOP_W'(SYNC_TICKS);
      end
    end
  end

  // counter
  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = refill;
    end else if (tick_i && run) begin
      if (at_zero) begin
        cnt_d = ctrl_q.oneshot ? '0 : refill;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ivl_q  <= '0;
      cnt_q  <= '0;
      stop_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      ivl_q  <= ivl_d;
      cnt_q  <= cnt_d;
      stop_q <= stop_d;
    end
  end

  always_comb begin
    ctrl_o   = ctrl_q;
    ivl_o    = ivl_q;
    cnt_o    = cnt_q;
    expire_o = expire;
  end

  // R4: a running nonzero count drops by exactly one per tick
  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && run && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R6: single-shot expiry without a control write drops enable
  a_r6_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && ctrl_q.oneshot && !wr_ctrl_i) |=> (!ctrl_q.enable && cnt_q == '0));

  // R7: the disable tail never exceeds the sync length
  a_r7_tail_bound: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q <= STOP_W'(SYNC_TICKS));

  // R7: a halted channel keeps its count unless reloaded
  a_r7_halted_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/dntimer_irq.sv
module dntimer_irq #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] expire_i,
  input  logic              wr_mask_i,
  input  logic              wr_pend_i,
  input  logic [NUM_CH-1:0] wbits_i,
  output logic [NUM_CH-1:0] mask_o,
  output logic [NUM_CH-1:0] pend_o,
  output logic              irq_o
);

  logic [NUM_CH-1:0] mask_q, mask_d;
  logic [NUM_CH-1:0] pend_q, pend_d;
  logic [NUM_CH-1:0] clr;

  always_comb begin
    clr    = wr_pend_i ? wbits_i : '0;
    pend_d = (pend_q & ~clr) | expire_i;
    mask_d = wr_mask_i ? wbits_i : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      pend_q <= '0;
    end else begin
      mask_q <= mask_d;
      pend_q <= pend_d;
    end
  end

  always_comb begin
    mask_o = mask_q;
    pend_o = pend_q;
    irq_o  = |(pend_q & mask_q);
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R5: a pending bit only rises after its channel expired
    a_r5_pend_source: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(pend_q[i]) && pend_q[i]) |-> $past(expire_i[i]));

    // R8: a pending bit with no clear request stays set
    a_r8_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[i] && !(wr_pend_i && wbits_i[i])) |=> pend_q[i]);
  end

  // R9: with every mask bit low the line stays low
  a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_o);

endmodule

// File: rtl/dntimer.sv
module dntimer
  import dntimer_pkg::*;
#(
  parameter int NUM_CH     = 2,
  parameter int WORD_W     = 32,
  parameter int ADDR_W     = 8,
  parameter int MIN_RELOAD = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              irq
);

  localparam int CNT_W     = 2 * WORD_W;
  localparam int CH_BASE   = 'h10;
  localparam int CH_STRIDE = 'h20;
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'('h04);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  always_comb begin
    rst_core_n = rst_sync_q[1];
  end

  logic [SEL_W-1:0]  sel   [NUM_CH];
  logic [NUM_CH-1:0] tick;
  logic [NUM_CH-1:0] expire;
  logic [NUM_CH-1:0] mask;
  logic [NUM_CH-1:0] pend;
  logic [WORD_W-1:0] ch_rd [NUM_CH];
  logic [NUM_CH-1:0] ch_hit;
  logic              wr_mask;
  logic              wr_pend;

  always_comb begin
    wr_mask = wr_en && (addr == A_MASK);
    wr_pend = wr_en && (addr == A_PEND);
  end

  dntimer_prescale #(
    .NUM_CH (NUM_CH)
  ) u_prescale (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .sel_i  (sel),
    .tick_o (tick)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int BASE = CH_BASE + CH_STRIDE * i;
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] A_IVL_LO = ADDR_W'(BASE + 'h04);
    localparam logic [ADDR_W-1:0] A_IVL_HI = ADDR_W'(BASE + 'h08);
    localparam logic [ADDR_W-1:0] A_CNT_LO = ADDR_W'(BASE + 'h0C);
    localparam logic [ADDR_W-1:0] A_CNT_HI = ADDR_W'(BASE + 'h10);

    chan_ctrl_t       ctrl;
    logic [CNT_W-1:0] ivl;
    logic [CNT_W-1:0] cnt;
    logic             wr_ctrl;
    logic             wr_ivl_lo;
    logic             wr_ivl_hi;

    always_comb begin
      wr_ctrl   = wr_en && (addr == A_CTRL);
      wr_ivl_lo = wr_en && (addr == A_IVL_LO);
      wr_ivl_hi = wr_en && (addr == A_IVL_HI);
      sel[i]    = ctrl.psel;
    end

    dntimer_channel #(
      .WORD_W     (WORD_W),
      .MIN_RELOAD (MIN_RELOAD)
    ) u_chan (
      .clk         (clk),
      .rst_n       (rst_core_n),
      .tick_i      (tick[i]),
      .wr_ctrl_i   (wr_ctrl),
      .wr_ivl_lo_i (wr_ivl_lo),
      .wr_ivl_hi_i (wr_ivl_hi),
      .wdata_i     (wdata),
      .ctrl_o      (ctrl),
      .ivl_o       (ivl),
      .cnt_o       (cnt),
      .expire_o    (expire[i])
    );

    always_comb begin
      ch_hit[i] = 1'b1;
      ch_rd[i]  = '0;
      unique case (addr)
        A_CTRL:   ch_rd[i] = WORD_W'(ctrl);
        A_IVL_LO: ch_rd[i] = ivl[WORD_W-1:0];
        A_IVL_HI: ch_rd[i] = ivl[CNT_W-1:WORD_W];
        A_CNT_LO: ch_rd[i] = cnt[WORD_W-1:0];
        A_CNT_HI: ch_rd[i] = cnt[CNT_W-1:WORD_W];
        default:  ch_hit[i] = 1'b0;
      endcase
    end
  end

  dntimer_irq #(
    .NUM_CH (NUM_CH)
  ) u_irq (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .expire_i  (expire),
    .wr_mask_i (wr_mask),
    .wr_pend_i (wr_pend),
    .wbits_i   (wdata[NUM_CH-1:0]),
    .mask_o    (mask),
    .pend_o    (pend),
    .irq_o     (irq)
  );

  always_comb begin
    rdata = '0;
    if (addr == A_MASK) begin
      rdata = WORD_W'(mask);
    end else if (addr == A_PEND) begin
      rdata = WORD_W'(pend);
    end
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_hit[i]) begin
        rdata = rdata | ch_rd[i];
      end
    end
  end

  // R2: the bus never reads two sources at once
  a_r2_single_source: assert property (@(posedge clk) disable iff (!rst_core_n)
    $onehot0(ch_hit));

endmodule

// File: tb/dntimer_test.sv
module dntimer_test;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [7:0]  addr;
  logic        wr_en;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  typedef struct {
    logic [7:0]  a;
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  sb_item_t sb_q [$];
  int       n_chk;
  int       n_fail;
  logic     rd_stb;
  logic     done;

  dntimer uut (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (addr),
    .wr_en (wr_en),
    .wdata (wdata),
    .rdata (rdata),
    .irq   (irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: compares each read against the queued expectation
  always @(negedge clk) begin
    #1;
    if (rd_stb && sb_q.size() > 0) begin
      sb_item_t it;
      it = sb_q.pop_front();
      n_chk++;
      if (rdata !== it.exp) begin
        n_fail++;
        $display("FAIL %s addr=%02h actual=%08h expected=%08h",
                 it.tag, it.a, rdata, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    rd_stb = 1'b0;
    addr   = a;
    wdata  = d;
    wr_en  = 1'b1;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    sb_item_t it;
    @(negedge clk);
    wr_en  = 1'b0;
    addr   = a;
    it.a   = a;
    it.exp = e;
    it.tag = tag;
    sb_q.push_back(it);
    rd_stb = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      wr_en  = 1'b0;
      rd_stb = 1'b0;
      addr   = 8'hFC;
    end
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    wr_en  = 1'b0;
    rd_stb = 1'b0;
    #1;
    n_chk++;
    if (irq !== e) begin
      n_fail++;
      $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, e);
    end
  endtask

  initial begin
    done = 1'b0;
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk  = 0;
    n_fail = 0;
    rd_stb = 1'b0;
    addr   = 8'h00;
    wr_en  = 1'b0;
    wdata  = '0;
    rst_n  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk_irq(1'b0, "R1");
    rd(8'h00, 32'h0, "R1");
    rd(8'h04, 32'h0, "R1");
    rd(8'h10, 32'h0, "R1");
    rd(8'h1C, 32'h0, "R1");
    rd(8'h30, 32'h0, "R1");

    // R3 load, R4 countdown at sel 0, R5 periodic refill
    wr(8'h14, 32'd5);
    wr(8'h18, 32'd0);
    wr(8'h10, 32'h3);
    rd(8'h1C, 32'd5, "R3");
    rd(8'h1C, 32'd4, "R4");
    rd(8'h1C, 32'd3, "R4");
    rd(8'h1C, 32'd2, "R4");
    rd(8'h1C, 32'd1, "R4");
    rd(8'h1C, 32'd0, "R4");
    rd(8'h1C, 32'd5, "R5");
    rd(8'h04, 32'h1, "R5");
    chk_irq(1'b0, "R9");
    wr(8'h00, 32'h1);
    chk_irq(1'b1, "R9");
    wr(8'h10, 32'h0);
    idle(10);
    wr(8'h04, 32'h1);
    rd(8'h04, 32'h0, "R8");
    chk_irq(1'b0, "R8");

    // R7 two-tick tail after disable
    wr(8'h34, 32'd100);
    wr(8'h10 + 8'h20, 32'h3);
    rd(8'h3C, 32'd100, "R3");
    wr(8'h30, 32'h0);
    rd(8'h3C, 32'd98, "R7");
    rd(8'h3C, 32'd97, "R7");
    rd(8'h3C, 32'd96, "R7");
    rd(8'h3C, 32'd96, "R7");
    rd(8'h30, 32'h0, "R7");

    // R4 prescale sel 2, R6 single shot
    wr(8'h34, 32'd3);
    wr(8'h30, 32'hA3);
    rd(8'h3C, 32'd3, "R3");
    idle(7);
    rd(8'h3C, 32'd1, "R4");
    idle(30);
    rd(8'h04, 32'h2, "R6");
    rd(8'h30, 32'hA2, "R6");
    rd(8'h3C, 32'd0, "R6");
    idle(20);
    rd(8'h3C, 32'd0, "R6");
    chk_irq(1'b0, "R9");
    wr(8'h00, 32'h3);
    chk_irq(1'b1, "R9");
    wr(8'h04, 32'h0);
    rd(8'h04, 32'h2, "R8");
    wr(8'h04, 32'h2);
    chk_irq(1'b0, "R8");

    // R2 map, read-only count, unmapped
    wr(8'h3C, 32'h1234);
    rd(8'h3C, 32'd0, "R2");
    wr(8'h38, 32'hABCD);
    rd(8'h38, 32'hABCD, "R2");
    rd(8'h40, 32'h0, "R2");
    rd(8'h08, 32'h0, "R2");
    rd(8'hFC, 32'h0, "R2");
    rd(8'h00, 32'h3, "R2");

    // R10 minimum refill
    wr(8'h14, 32'd0);
    wr(8'h10, 32'h3);
    rd(8'h1C, 32'd2, "R10");
    rd(8'h1C, 32'd1, "R10");
    rd(8'h1C, 32'd0, "R10");
    rd(8'h1C, 32'd2, "R10");
    rd(8'h10, 32'h3, "R3");

    idle(3);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule